// File: doc/BRIEF.md
# Range-Based Memory Protection Checker

This block stands in front of a shared memory and decides, for every bus access, whether that access may go ahead. An access carries an address, an initiator number, a privilege level (supervisor or user) and a kind (read, write or execute). Six programmable ranges describe the policy. Each range has a first address, an inclusive last address and a permission word. The permission word holds six access-right bits and one enable bit for each initiator.

The policy removes rights and never adds them. A range takes part in an access only when the address lies inside the range and the range enables the access's initiator. An access that no range takes part in goes through. If any range that takes part lacks the right the access needs, the access is refused, so the order of the ranges has no effect. After reset every range covers the whole protected region and grants every right to every initiator, so a range that has never been programmed changes nothing.

The decision is registered one cycle after the request. It comes out with the address, initiator, privilege and kind of the access, so that a fault logger downstream can record refused accesses. A simple write port programs the ranges, and a combinational read port returns their contents and a read-only mode word.

Top module: `mem_prot_check`

## Requirements
- R1: After reset, every range n (0 to 5) reads back first address REGION_BASE at offset 0x200+0x10·n, last address REGION_LAST at offset 0x204+0x10·n, and permission word 0x03FFFEBF at offset 0x208+0x10·n.
- R2: A write with cfg_we high to a range offset updates that word in the next cycle. Bit 7 of a permission word always reads back as 1, whatever value was written to it.
- R3: The mode word at offset 0x004 reads 0x00000001, where bit 0 set means that unmatched accesses are allowed. Writes to this offset are ignored.
- R4: A range takes part in an access only when first ≤ address ≤ last (both ends inclusive) and permission bit 10+id is set for the access's initiator id.
- R5: The right tested is selected by permission bit 5 (supervisor read), 4 (supervisor write), 3 (supervisor execute), 2 (user read), 1 (user write) or 0 (user execute). acc_priv=1 means supervisor. acc_kind is 0 for read, 1 for write, and 2 or 3 for execute.
- R6: If any range that takes part has the selected right clear, the access is refused. Range order has no effect.
- R7: An access that no range takes part in is allowed.
- R8: Initiator ids of NUM_INIT (16) or more never take part in any range, so their accesses are always allowed.
- R9: One cycle after acc_valid is high, res_valid is 1 and exactly one of res_allow or res_fault is 1. The address, id, privilege and kind of the access are presented alongside. After a cycle with acc_valid low, res_valid, res_allow and res_fault are 0 and the attribute outputs hold their values.
- R10: An access in the same cycle as a programming write is judged with the range contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Programming write strobe |
| cfg_addr | input | 12 | Programming write byte offset |
| cfg_wdata | input | 32 | Programming write data |
| cfg_rd_addr | input | 12 | Read-back byte offset |
| cfg_rd_data | output | 32 | Read-back data (combinational) |
| acc_valid | input | 1 | Access request present |
| acc_addr | input | 32 | Access address |
| acc_id | input | 5 | Initiator number |
| acc_priv | input | 1 | 1 = supervisor, 0 = user |
| acc_kind | input | 2 | 0 read, 1 write, 2/3 execute |
| res_valid | output | 1 | Registered decision present |
| res_allow | output | 1 | Access allowed |
| res_fault | output | 1 | Access refused |
| res_addr | output | 32 | Address of the judged access |
| res_id | output | 5 | Initiator of the judged access |
| res_priv | output | 1 | Privilege of the judged access |
| res_kind | output | 2 | Kind of the judged access |

## Verification
A programming write and an access can land in the same clock cycle. The hazard is that the access might be judged against the new range contents rather than the old ones. The bench drives both on one falling edge. For example, it strips every right from a range that currently grants all of them while an access hits that range. It expects the decision from the pre-write model, and only then applies the write to its model. A second access afterwards confirms that the new contents are in force from the following cycle.

// File: rtl/mprot_pkg.sv
package mprot_pkg;

    parameter int ADDR_W   = 32;
    parameter int DATA_W   = 32;
    parameter int ID_W     = 5;
    parameter int CFG_AW   = 12;

    localparam int EN_LSB      = 10;
    localparam int RSV_ONE_BIT = 7;

    localparam logic [DATA_W-1:0] PERM_RST    = 32'h03FF_FEBF;
    localparam logic [CFG_AW-1:0] MODE_OFS    = 12'h004;
    localparam logic [3:0]        RANGE_PAGE  = 4'h2;
    localparam logic [DATA_W-1:0] MODE_WORD   = 32'h0000_0001;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_EXEC2 = 2'd3
    } acc_kind_e;

    typedef enum logic [1:0] {
        FLD_FIRST = 2'd0,
        FLD_LAST  = 2'd1,
        FLD_PERM  = 2'd2,
        FLD_NONE  = 2'd3
    } cfg_fld_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [ID_W-1:0]   id;
        logic              priv;
        acc_kind_e         kind;
    } acc_attr_t;

    typedef struct packed {
        logic [ADDR_W-1:0] first_a;
        logic [ADDR_W-1:0] last_a;
        logic [DATA_W-1:0] perm;
    } range_cfg_t;

    // Position of the access-right bit that governs this access.
    function automatic logic [2:0] right_pos(logic priv, acc_kind_e kind);
        logic [2:0] base;
        case (kind)
            ACC_READ:  base = 3'd2;
            ACC_WRITE: base = 3'd1;
            default:   base = 3'd0;
        endcase
        return priv ? base + 3'd3 : base;
    endfunction

endpackage

// File: rtl/mprot_regfile.sv
module mprot_regfile
    import mprot_pkg::*;
#(
    parameter int                NUM_RANGES  = 6,
    parameter logic [ADDR_W-1:0] REGION_BASE = 32'h8000_0000,
    parameter logic [ADDR_W-1:0] REGION_LAST = 32'h8001_FFFF
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          cfg_we,
    input  logic [CFG_AW-1:0]             cfg_addr,
    input  logic [DATA_W-1:0]             cfg_wdata,
    input  logic [CFG_AW-1:0]             cfg_rd_addr,
    output logic [DATA_W-1:0]             cfg_rd_data,
    output range_cfg_t [NUM_RANGES-1:0]   ranges
);

    localparam range_cfg_t RANGE_RST = '{first_a: REGION_BASE,
                                         last_a:  REGION_LAST,
                                         perm:    PERM_RST};

    logic       wr_page;
    logic [3:0] wr_idx;
    cfg_fld_e   wr_fld;
    logic       rd_page;
    logic [3:0] rd_idx;
    cfg_fld_e   rd_fld;

    assign wr_page = (cfg_addr[CFG_AW-1:8] == RANGE_PAGE) && (cfg_addr[1:0] == 2'b00);
    assign wr_idx  = cfg_addr[7:4];
    assign wr_fld  = cfg_fld_e'(cfg_addr[3:2]);
    assign rd_page = (cfg_rd_addr[CFG_AW-1:8] == RANGE_PAGE) && (cfg_rd_addr[1:0] == 2'b00);
    assign rd_idx  = cfg_rd_addr[7:4];
    assign rd_fld  = cfg_fld_e'(cfg_rd_addr[3:2]);

    for (genvar g = 0; g < NUM_RANGES; g++) begin : g_range
        logic sel;
        assign sel = cfg_we && wr_page && (wr_idx == 4'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                ranges[g] <= RANGE_RST;
            end else if (sel) begin
                case (wr_fld)
                    FLD_FIRST: ranges[g].first_a <= cfg_wdata;
                    FLD_LAST:  ranges[g].last_a  <= cfg_wdata;
                    FLD_PERM:  ranges[g].perm    <= cfg_wdata | (DATA_W'(1) << RSV_ONE_BIT);
                    default:   ;
                endcase
            end
        end
    end

    always_comb begin
        cfg_rd_data = '0;
        if (cfg_rd_addr == MODE_OFS) begin
            cfg_rd_data = MODE_WORD;
        end else if (rd_page && (int'(rd_idx) < NUM_RANGES)) begin
            case (rd_fld)
                FLD_FIRST: cfg_rd_data = ranges[rd_idx].first_a;
                FLD_LAST:  cfg_rd_data = ranges[rd_idx].last_a;
                FLD_PERM:  cfg_rd_data = ranges[rd_idx].perm;
                default:   cfg_rd_data = '0;
            endcase
        end
    end

endmodule

// File: rtl/mprot_range_eval.sv
module mprot_range_eval
    import mprot_pkg::*;
#(
    parameter int NUM_INIT = 16
) (
    input  range_cfg_t cfg,
    input  acc_attr_t  acc,
    output logic       takes_part,
    output logic       grants
);

    localparam int SEL_W = (NUM_INIT > 1) ? $clog2(NUM_INIT) : 1;

    logic [NUM_INIT-1:0] en_vec;
    logic                id_known;
    logic                in_span;

    assign en_vec     = cfg.perm[EN_LSB +: NUM_INIT];
    assign id_known   = (int'(acc.id) < NUM_INIT);
    assign in_span    = (acc.addr >= cfg.first_a) && (acc.addr <= cfg.last_a);
    assign takes_part = in_span && id_known && en_vec[acc.id[SEL_W-1:0]];
    assign grants     = cfg.perm[right_pos(acc.priv, acc.kind)];

endmodule

// File: rtl/mem_prot_check.sv
module mem_prot_check
    import mprot_pkg::*;
#(
    parameter int                NUM_RANGES  = 6,
    parameter int                NUM_INIT    = 16,
    parameter logic [ADDR_W-1:0] REGION_BASE = 32'h8000_0000,
    parameter logic [ADDR_W-1:0] REGION_LAST = 32'h8001_FFFF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [11:0]       cfg_addr,
    input  logic [31:0]       cfg_wdata,
    input  logic [11:0]       cfg_rd_addr,
    output logic [31:0]       cfg_rd_data,
    input  logic              acc_valid,
    input  logic [31:0]       acc_addr,
    input  logic [4:0]        acc_id,
    input  logic              acc_priv,
    input  logic [1:0]        acc_kind,
    output logic              res_valid,
    output logic              res_allow,
    output logic              res_fault,
    output logic [31:0]       res_addr,
    output logic [4:0]        res_id,
    output logic              res_priv,
    output logic [1:0]        res_kind
);

    range_cfg_t [NUM_RANGES-1:0] ranges;
    acc_attr_t                   acc;
    acc_attr_t                   held;
    logic [NUM_RANGES-1:0]       part_vec;
    logic [NUM_RANGES-1:0]       grant_vec;
    logic                        refuse;

    assign acc = '{addr: acc_addr, id: acc_id, priv: acc_priv, kind: acc_kind_e'(acc_kind)};

    mprot_regfile #(
        .NUM_RANGES (NUM_RANGES),
        .REGION_BASE(REGION_BASE),
        .REGION_LAST(REGION_LAST)
    ) regs_i (
        .clk        (clk),
        .rst        (rst),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .cfg_rd_addr(cfg_rd_addr),
        .cfg_rd_data(cfg_rd_data),
        .ranges     (ranges)
    );

    for (genvar g = 0; g < NUM_RANGES; g++) begin : g_eval
        mprot_range_eval #(.NUM_INIT(NUM_INIT)) eval_i (
            .cfg       (ranges[g]),
            .acc       (acc),
            .takes_part(part_vec[g]),
            .grants    (grant_vec[g])
        );
    end

    assign refuse = |(part_vec & ~grant_vec);

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_allow <= 1'b0;
            res_fault <= 1'b0;
            held      <= '0;
        end else begin
            res_valid <= acc_valid;
            res_allow <= acc_valid && !refuse;
            res_fault <= acc_valid && refuse;
            if (acc_valid) held <= acc;
        end
    end

    assign res_addr = held.addr;
    assign res_id   = held.id;
    assign res_priv = held.priv;
    assign res_kind = held.kind;

endmodule

// File: rtl/mprot_check.sv
module mprot_check #(
    parameter int NUM_RANGES = 6,
    parameter int NUM_INIT   = 16
) (
    input logic        clk,
    input logic        rst,
    input logic [11:0] cfg_rd_addr,
    input logic [31:0] cfg_rd_data,
    input logic        acc_valid,
    input logic [31:0] acc_addr,
    input logic [4:0]  acc_id,
    input logic        res_valid,
    input logic        res_allow,
    input logic        res_fault,
    input logic [31:0] res_addr,
    input logic [4:0]  res_id
);

    logic rd_is_perm;
    assign rd_is_perm = (cfg_rd_addr[11:8] == 4'h2) && (cfg_rd_addr[3:0] == 4'h8)
                        && (int'(cfg_rd_addr[7:4]) < NUM_RANGES);

    // R9
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        acc_valid |=> res_valid);

    // R9
    idle_out_chk: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |=> (!res_valid && !res_allow && !res_fault));

    // R9
    one_verdict_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> $countones({res_allow, res_fault}) == 1);

    // R9
    attr_capture_chk: assert property (@(posedge clk) disable iff (rst)
        acc_valid |=> (res_addr == $past(acc_addr) && res_id == $past(acc_id)));

    // R9
    attr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |=> ($stable(res_addr) && $stable(res_id)));

    // R8
    foreign_id_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && int'(acc_id) >= NUM_INIT) |=> res_allow);

    // R2
    rsv_bit_chk: assert property (@(posedge clk) disable iff (rst)
        rd_is_perm |-> cfg_rd_data[7]);

    // R3
    mode_word_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_rd_addr == 12'h004) |-> (cfg_rd_data == 32'h1));

endmodule

bind mem_prot_check mprot_check #(
    .NUM_RANGES(NUM_RANGES),
    .NUM_INIT  (NUM_INIT)
) chk_i (.*);

// File: tb/mem_prot_check_tb_top.sv
module mem_prot_check_tb_top;

    localparam int          NR    = 6;
    localparam int          NI    = 16;
    localparam logic [31:0] BASE  = 32'h8000_0000;
    localparam logic [31:0] LAST  = 32'h8001_FFFF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [11:0] cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [11:0] cfg_rd_addr = '0;
    logic [31:0] cfg_rd_data;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic [4:0]  acc_id = '0;
    logic        acc_priv = 1'b0;
    logic [1:0]  acc_kind = '0;
    logic        res_valid, res_allow, res_fault, res_priv;
    logic [31:0] res_addr;
    logic [4:0]  res_id;
    logic [1:0]  res_kind;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic [31:0] m_first [NR];
    logic [31:0] m_last  [NR];
    logic [31:0] m_perm  [NR];

    always #4 clk = ~clk;

    mem_prot_check dut_i (.*);

    function automatic logic [11:0] ofs(int n, int f);
        return 12'(32'h200 + n * 16 + f * 4);
    endfunction

    function automatic int rbit(logic priv, logic [1:0] kind);
        int b;
        b = (kind == 2'd0) ? 2 : (kind == 2'd1) ? 1 : 0;
        return priv ? b + 3 : b;
    endfunction

    function automatic logic ref_allow(logic [31:0] a, logic [4:0] id, logic priv, logic [1:0] kind);
        logic ok;
        ok = 1'b1;
        for (int r = 0; r < NR; r++) begin
            if (a >= m_first[r] && a <= m_last[r] && int'(id) < NI
                && m_perm[r][10 + int'(id)] && !m_perm[r][rbit(priv, kind)])
                ok = 1'b0;
        end
        return ok;
    endfunction

    task automatic check(bit cond, string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic model_reset();
        for (int r = 0; r < NR; r++) begin
            m_first[r] = BASE;
            m_last[r]  = LAST;
            m_perm[r]  = 32'h03FF_FEBF;
        end
    endtask

    task automatic model_write(logic [11:0] a, logic [31:0] d);
        int n;
        n = int'(a[7:4]);
        if (a[11:8] == 4'h2 && a[1:0] == 2'b00 && n < NR) begin
            case (a[3:2])
                2'd0: m_first[n] = d;
                2'd1: m_last[n]  = d;
                2'd2: m_perm[n]  = d | 32'h80;
                default: ;
            endcase
        end
    endtask

    // Called right after a negedge; returns right after the next negedge.
    task automatic cfg_write(logic [11:0] a, logic [31:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        model_write(a, d);
    endtask

    task automatic readback(logic [11:0] a, logic [31:0] exp, string req);
        cfg_rd_addr = a;
        #1;
        check(cfg_rd_data == exp, req, 64'(cfg_rd_data), 64'(exp));
    endtask

    task automatic access(logic [31:0] a, logic [4:0] id, logic priv, logic [1:0] kind,
                          string req, bit with_wr = 0,
                          logic [11:0] wa = '0, logic [31:0] wd = '0);
        logic exp;
        exp = ref_allow(a, id, priv, kind);
        acc_valid = 1'b1; acc_addr = a; acc_id = id; acc_priv = priv; acc_kind = kind;
        if (with_wr) begin cfg_we = 1'b1; cfg_addr = wa; cfg_wdata = wd; end
        @(negedge clk);
        acc_valid = 1'b0; cfg_we = 1'b0;
        if (with_wr) model_write(wa, wd);
        check(res_valid && res_allow == exp && res_fault == !exp
              && res_addr == a && res_id == id && res_priv == priv && res_kind == kind,
              req, {res_valid, res_allow, res_fault, res_addr, res_id, res_priv, res_kind},
              {1'b1, exp, !exp, a, id, priv, kind});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        void'($urandom(32'd2024));
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R9: reset state of outputs
        check(!res_valid && !res_allow && !res_fault, "R9 reset outputs",
              {res_valid, res_allow, res_fault}, 0);

        // R1: reset readback of all ranges
        for (int n = 0; n < NR; n++) begin
            readback(ofs(n, 0), BASE, "R1 first reset");
            readback(ofs(n, 1), LAST, "R1 last reset");
            readback(ofs(n, 2), 32'h03FF_FEBF, "R1 perm reset");
        end
        // R3: mode word, then a write to it is ignored
        readback(12'h004, 32'h1, "R3 mode word");
        cfg_write(12'h004, 32'h0);
        readback(12'h004, 32'h1, "R3 mode write ignored");

        // R7/R6: unprogrammed ranges let everything through
        access(BASE, 5'd0, 1'b0, 2'd1, "R7 reset config allows");

        // R2: bit 7 forced to one on readback
        cfg_write(ofs(2, 0), 32'h8000_6000);
        cfg_write(ofs(2, 1), 32'h8000_FFFF);
        cfg_write(ofs(2, 2), 32'h03FF_FC00);
        readback(ofs(2, 0), 32'h8000_6000, "R2 first written");
        readback(ofs(2, 2), 32'h03FF_FC80, "R2 bit7 reads one");

        // R4/R6: range 2 strips every right from all initiators
        access(32'h8000_6000, 5'd0, 1'b1, 2'd1, "R6 denied at first address");
        access(32'h8000_5FFF, 5'd0, 1'b1, 2'd1, "R4 below first allowed");
        access(32'h8000_FFFF, 5'd1, 1'b0, 2'd0, "R4 last address inclusive");
        access(32'h8001_0000, 5'd1, 1'b0, 2'd2, "R4 above last allowed");
        // R8: foreign initiator never matches
        access(32'h8000_6000, 5'd20, 1'b1, 2'd1, "R8 foreign id allowed");
        access(32'h8000_6000, 5'd16, 1'b0, 2'd0, "R8 id 16 allowed");

        // R4: range enabling only initiator 1 (bit 11) with no rights
        cfg_write(ofs(2, 2), 32'h0000_0800);
        access(32'h8000_7000, 5'd0, 1'b1, 2'd0, "R4 disabled id passes");
        access(32'h8000_7000, 5'd1, 1'b1, 2'd0, "R4 enabled id refused");

        // R5: single right per kind/privilege
        for (int b = 0; b < 6; b++) begin
            cfg_write(ofs(2, 2), 32'h0000_0400 | (32'h1 << b));
            for (int p = 0; p < 2; p++)
                for (int k = 0; k < 4; k++)
                    access(32'h8000_8000, 5'd0, p[0], k[1:0], "R5 right select");
        end

        // R6: overlapping ranges, any refusal wins
        cfg_write(ofs(3, 2), 32'h0000_043F);
        cfg_write(ofs(4, 2), 32'h0000_0C1F);
        access(32'h8000_0100, 5'd0, 1'b1, 2'd0, "R6 one range refuses");

        // R10: write and access in the same cycle
        model_reset();
        rst = 1'b1; @(negedge clk); rst = 1'b0; @(negedge clk);
        access(32'h8000_1000, 5'd0, 1'b0, 2'd1, "R10 old contents used", 1,
               ofs(0, 2), 32'h0000_0400);
        access(32'h8000_1000, 5'd0, 1'b0, 2'd1, "R10 new contents next cycle");

        // R9: idle cycle keeps attributes, clears verdict
        @(negedge clk);
        check(!res_valid && !res_allow && !res_fault && res_addr == 32'h8000_1000,
              "R9 idle hold", {res_valid, res_allow, res_fault, res_addr},
              {3'b000, 32'h8000_1000});

        // Random phase
        for (int it = 0; it < 60; it++) begin
            for (int n = 0; n < NR; n++) begin
                logic [31:0] s, e;
                s = BASE + ($urandom % 32'h20000);
                e = (($urandom % 8) == 0) ? s - 1 : s + ($urandom % 32'h8000);
                cfg_write(ofs(n, 0), s);
                cfg_write(ofs(n, 1), e);
                cfg_write(ofs(n, 2), ($urandom & 32'h0000_3CFF) | (($urandom % 2) ? 32'h03FF_C000 : 0));
            end
            for (int j = 0; j < 40; j++) begin
                logic [4:0] id;
                id = (($urandom % 6) == 0) ? 5'(16 + $urandom % 16) : 5'($urandom % 4);
                if (($urandom % 10) == 0)
                    access(BASE + ($urandom % 32'h28000), id, 1'($urandom), 2'($urandom),
                           "R10 random write overlap", 1,
                           ofs(int'($urandom % NR), 2), $urandom);
                else
                    access(BASE + ($urandom % 32'h28000), id, 1'($urandom), 2'($urandom),
                           "R6 random decision");
            end
        end

        finish_run();
    end

endmodule